// File: doc/BRIEF.md
# Unprivileged Load/Store Address Unit

This unit prepares the memory request for a load or store that must run with user-level rights, whatever mode the processor is in. It takes the base register, an offset register, an immediate, an addressing-mode select, a direction flag, a shift kind and amount with the carry flag, an access size code and the store data. It produces one registered request: the address, a privilege bit that always marks user level, per-byte lane enables and the store data copied across lanes. It also gives a base-register writeback value and its enable. A request that breaks an encoding rule raises an error pulse and issues no access.

The unit supports three addressing modes. In offset mode the address is the base plus a small unsigned immediate, and the base is left alone. In the two post-indexed modes the base itself is the address, and the base is updated by an immediate or by a shifted register, added or subtracted. For loads, raw read data from memory is steered from the lane picked by the registered address and extended to 32 bits, with zero or sign fill as the size code asks.

Top module: `user_ldst_agen`

## Requirements
- R1: Every issued request (`mem_valid_o` high) carries `mem_user_o` = 1, marking user privilege.
- R2: With mode 0 (offset), the address is base plus the zero-extended immediate, the immediate may not exceed 255, and `wb_en_o` stays low.
- R3: With mode 1 (post-indexed by immediate) or mode 2 (post-indexed by register), the address equals the unmodified base, `wb_en_o` is high, and `wb_value_o` is base plus the offset, or base minus the offset when `req_sub_i` = 1.
- R4: The mode 1 immediate may reach 4095 for sizes 0 (unsigned byte) and 4 (word), but only 255 for sizes 1 (signed byte), 2 (unsigned half) and 3 (signed half). A larger value, mode 3, or a size code of 5 to 7 gives `err_o` = 1 and `mem_valid_o` = 0.
- R5: In mode 2 the offset register is shifted by kind 0 = LSL by amount 0..31, kind 1 = LSR, kind 2 = ASR or kind 3 = ROR. For LSR and ASR an amount of 0 means 32: LSR gives zero, and ASR fills every bit with bit 31. For ROR an amount of 0 means RRX, a right shift by one with `carry_i` entering bit 31.
- R6: In mode 2 the shift is applied only for sizes 0 and 4. For any other size the register is used unshifted.
- R7: `ld_result_o` extracts from `rdata_i` the byte at lane addr[1:0] (sizes 0/1) or the halfword at lane addr[1] (sizes 2/3) of the last issued request, zero-extended for sizes 0/2 and sign-extended for 1/3. For size 4 it passes the word through.
- R8: A store (`req_store_i` = 1) with size 1 or 3 gives `err_o` = 1 and no request.
- R9: In mode 2, `offreg_is_pc_i` = 1 gives `err_o` = 1 and no request.
- R10: Lane enables are little-endian. A byte sets bit addr[1:0], a halfword sets bits 1:0 or 3:2 by addr[1], and a word sets all four. Store data repeats the byte four times or the halfword twice, and loads drive `mem_wdata_o` = 0.
- R11: Outputs register one cycle after `req_valid_i`, and `err_o` and `mem_valid_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_mode_i | input | 2 | 0 offset, 1 post-imm, 2 post-reg, 3 reserved |
| req_sub_i | input | 1 | Subtract the offset from the base |
| req_size_i | input | 3 | 0 UB, 1 SB, 2 UH, 3 SH, 4 W |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Unsigned immediate magnitude |
| offreg_i | input | 32 | Offset register value |
| offreg_is_pc_i | input | 1 | Offset register is the program counter |
| shift_kind_i | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shift_amt_i | input | 5 | Shift amount (0 coded as in R5) |
| carry_i | input | 1 | Carry flag for RRX |
| st_data_i | input | 32 | Store source value |
| rdata_i | input | 32 | Raw read data from memory |
| mem_valid_o | output | 1 | Request issued |
| mem_we_o | output | 1 | Request is a write |
| mem_user_o | output | 1 | User-privilege marker |
| mem_addr_o | output | 32 | Access address |
| mem_be_o | output | 4 | Byte lane enables |
| mem_wdata_o | output | 32 | Lane-replicated store data |
| wb_en_o | output | 1 | Base writeback enable |
| wb_value_o | output | 32 | Updated base value |
| err_o | output | 1 | Illegal request |
| ld_result_o | output | 32 | Extended load result |

## Verification
On every cycle the assertions check several properties that relate the registered outputs to the request one cycle earlier. They cover the user marker on issued requests, an offset-mode address of base plus immediate, and a post-indexed address equal to the old base. They also check that offset mode never writes back, that a signed store is rejected, that error and issue stay exclusive, and that the lane-enable population count fits the access. The arithmetic of the writeback value is left to the bench's scenarios, which alone can show it: every shift kind with its zero-amount special meaning, the unshifted halfword offset, the range limits per size, and zero and sign extension from each lane.

// File: rtl/user_ldst_pkg.sv
package user_ldst_pkg;

    localparam int XLEN            = 32;
    localparam int LANES           = XLEN / 8;
    localparam int LANE_AW         = $clog2(LANES);
    localparam int IMM_W           = 12;
    localparam int SHAMT_W         = 5;
    localparam int OFFS_MODE_MAX   = 255;
    localparam int POST_WIDE_MAX   = 4095;
    localparam int POST_NARROW_MAX = 255;

    typedef enum logic [1:0] {
        AM_OFFS     = 2'd0,
        AM_POST_IMM = 2'd1,
        AM_POST_REG = 2'd2,
        AM_RSVD     = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shkind_e;

    typedef enum logic [2:0] {
        SZ_UB = 3'd0,
        SZ_SB = 3'd1,
        SZ_UH = 3'd2,
        SZ_SH = 3'd3,
        SZ_W  = 3'd4
    } asize_e;

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wb_value;
        logic            wb_needed;
        logic            illegal;
    } agen_res_t;

    function automatic logic size_known(input logic [2:0] sz);
        return sz <= 3'(SZ_W);
    endfunction

    function automatic logic size_signed(input logic [2:0] sz);
        return (sz == 3'(SZ_SB)) || (sz == 3'(SZ_SH));
    endfunction

    function automatic logic size_wide(input logic [2:0] sz);
        return (sz == 3'(SZ_UB)) || (sz == 3'(SZ_W));
    endfunction

    function automatic logic size_byte(input logic [2:0] sz);
        return (sz == 3'(SZ_UB)) || (sz == 3'(SZ_SB));
    endfunction

    function automatic logic size_half(input logic [2:0] sz);
        return (sz == 3'(SZ_UH)) || (sz == 3'(SZ_SH));
    endfunction

endpackage

// File: rtl/uldst_shifter.sv
module uldst_shifter
    import user_ldst_pkg::*;
(
    input  logic [XLEN-1:0]    val_i,
    input  logic [1:0]         kind_i,
    input  logic [SHAMT_W-1:0] amt_i,
    input  logic               carry_i,
    input  logic               bypass_i,
    output logic [XLEN-1:0]    val_o
);
    logic [XLEN-1:0] lsl_v, lsr_v, asr_v, ror_v;
    logic            amt_zero;

    assign amt_zero = (amt_i == '0);

    always_comb begin
        lsl_v = val_i << amt_i;
        lsr_v = amt_zero ? '0 : (val_i >> amt_i);
        asr_v = amt_zero ? {XLEN{val_i[XLEN-1]}}
                         : XLEN'($signed(val_i) >>> amt_i);
        ror_v = amt_zero ? {carry_i, val_i[XLEN-1:1]}
                         : ((val_i >> amt_i) | (val_i << (XLEN - int'(amt_i))));
    end

    always_comb begin
        if (bypass_i) begin
            val_o = val_i;
        end else begin
            unique case (shkind_e'(kind_i))
                SK_LSL:  val_o = lsl_v;
                SK_LSR:  val_o = lsr_v;
                SK_ASR:  val_o = asr_v;
                default: val_o = ror_v;
            endcase
        end
    end
endmodule

// File: rtl/uldst_addr_calc.sv
module uldst_addr_calc
    import user_ldst_pkg::*;
(
    input  logic             store_i,
    input  logic [1:0]       mode_i,
    input  logic             sub_i,
    input  logic [2:0]       size_i,
    input  logic [XLEN-1:0]  base_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [XLEN-1:0]  shifted_i,
    input  logic             offreg_is_pc_i,
    output agen_res_t        res_o
);
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] post_off;
    logic            range_bad;
    logic            enc_bad;
    amode_e          mode;

    assign mode    = amode_e'(mode_i);
    assign imm_ext = XLEN'(imm_i);

    always_comb begin
        range_bad = 1'b0;
        unique case (mode)
            AM_OFFS:     range_bad = (imm_i > IMM_W'(OFFS_MODE_MAX));
            AM_POST_IMM: range_bad = size_wide(size_i)
                                   ? (imm_i > IMM_W'(POST_WIDE_MAX))
                                   : (imm_i > IMM_W'(POST_NARROW_MAX));
            default:     range_bad = 1'b0;
        endcase
    end

    always_comb begin
        enc_bad = (mode == AM_RSVD)
               || !size_known(size_i)
               || (store_i && size_signed(size_i))
               || ((mode == AM_POST_REG) && offreg_is_pc_i);
    end

    assign post_off = (mode == AM_POST_REG) ? shifted_i : imm_ext;

    always_comb begin
        res_o.illegal   = enc_bad || range_bad;
        res_o.wb_needed = (mode == AM_POST_IMM) || (mode == AM_POST_REG);
        res_o.addr      = (mode == AM_OFFS) ? (base_i + imm_ext) : base_i;
        res_o.wb_value  = sub_i ? (base_i - post_off) : (base_i + post_off);
    end
endmodule

// File: rtl/uldst_lane_fmt.sv
module uldst_lane_fmt
    import user_ldst_pkg::*;
(
    input  logic               st_store_i,
    input  logic [LANE_AW-1:0] st_lane_i,
    input  logic [2:0]         st_size_i,
    input  logic [XLEN-1:0]    st_data_i,
    output logic [LANES-1:0]   be_o,
    output logic [XLEN-1:0]    wdata_o,
    input  logic [LANE_AW-1:0] ld_lane_i,
    input  logic [2:0]         ld_size_i,
    input  logic [XLEN-1:0]    rdata_i,
    output logic [XLEN-1:0]    ld_result_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic hit;
        logic [7:0] src;
        always_comb begin
            if (size_byte(st_size_i)) begin
                hit = (st_lane_i == LANE_AW'(i));
                src = st_data_i[7:0];
            end else if (size_half(st_size_i)) begin
                hit = (st_lane_i[LANE_AW-1] == ((i / 2) == 1));
                src = st_data_i[8*(i%2) +: 8];
            end else begin
                hit = 1'b1;
                src = st_data_i[8*i +: 8];
            end
        end
        assign be_o[i]          = hit;
        assign wdata_o[8*i +: 8] = st_store_i ? src : 8'h00;
    end

    logic [7:0]  ld_byte;
    logic [15:0] ld_half;

    assign ld_byte = rdata_i[8*ld_lane_i +: 8];
    assign ld_half = ld_lane_i[LANE_AW-1] ? rdata_i[31:16] : rdata_i[15:0];

    always_comb begin
        unique case (ld_size_i)
            3'(SZ_UB): ld_result_o = XLEN'(ld_byte);
            3'(SZ_SB): ld_result_o = {{(XLEN-8){ld_byte[7]}}, ld_byte};
            3'(SZ_UH): ld_result_o = XLEN'(ld_half);
            3'(SZ_SH): ld_result_o = {{(XLEN-16){ld_half[15]}}, ld_half};
            default:   ld_result_o = rdata_i;
        endcase
    end
endmodule

// File: rtl/user_ldst_agen.sv
module user_ldst_agen
    import user_ldst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid_i,
    input  logic             req_store_i,
    input  logic [1:0]       req_mode_i,
    input  logic             req_sub_i,
    input  logic [2:0]       req_size_i,
    input  logic [31:0]      base_i,
    input  logic [11:0]      imm_i,
    input  logic [31:0]      offreg_i,
    input  logic             offreg_is_pc_i,
    input  logic [1:0]       shift_kind_i,
    input  logic [4:0]       shift_amt_i,
    input  logic             carry_i,
    input  logic [31:0]      st_data_i,
    input  logic [31:0]      rdata_i,
    output logic             mem_valid_o,
    output logic             mem_we_o,
    output logic             mem_user_o,
    output logic [31:0]      mem_addr_o,
    output logic [3:0]       mem_be_o,
    output logic [31:0]      mem_wdata_o,
    output logic             wb_en_o,
    output logic [31:0]      wb_value_o,
    output logic             err_o,
    output logic [31:0]      ld_result_o
);
    localparam logic PRIV_USER = 1'b1;

    logic [XLEN-1:0]  shifted;
    agen_res_t        ag;
    logic [LANES-1:0] be_nxt;
    logic [XLEN-1:0]  wdata_nxt;

    logic             valid_q, we_q, user_q, wb_en_q, err_q;
    logic [XLEN-1:0]  addr_q, wb_q, wdata_q;
    logic [LANES-1:0] be_q;
    logic [2:0]       size_q;

    uldst_shifter u_shift (
        .val_i    (offreg_i),
        .kind_i   (shift_kind_i),
        .amt_i    (shift_amt_i),
        .carry_i  (carry_i),
        .bypass_i (!size_wide(req_size_i)),
        .val_o    (shifted)
    );

    uldst_addr_calc u_addr (
        .store_i        (req_store_i),
        .mode_i         (req_mode_i),
        .sub_i          (req_sub_i),
        .size_i         (req_size_i),
        .base_i         (base_i),
        .imm_i          (imm_i),
        .shifted_i      (shifted),
        .offreg_is_pc_i (offreg_is_pc_i),
        .res_o          (ag)
    );

    uldst_lane_fmt u_lane (
        .st_store_i  (req_store_i),
        .st_lane_i   (ag.addr[LANE_AW-1:0]),
        .st_size_i   (req_size_i),
        .st_data_i   (st_data_i),
        .be_o        (be_nxt),
        .wdata_o     (wdata_nxt),
        .ld_lane_i   (addr_q[LANE_AW-1:0]),
        .ld_size_i   (size_q),
        .rdata_i     (rdata_i),
        .ld_result_o (ld_result_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            wb_en_q <= 1'b0;
            we_q    <= 1'b0;
            user_q  <= 1'b0;
            addr_q  <= '0;
            wb_q    <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            size_q  <= 3'(SZ_W);
        end else begin
            valid_q <= req_valid_i && !ag.illegal;
            err_q   <= req_valid_i && ag.illegal;
            wb_en_q <= req_valid_i && !ag.illegal && ag.wb_needed;
            if (req_valid_i) begin
                we_q    <= req_store_i;
                user_q  <= PRIV_USER;
                addr_q  <= ag.addr;
                wb_q    <= ag.wb_value;
                wdata_q <= wdata_nxt;
                be_q    <= be_nxt;
                size_q  <= req_size_i;
            end
        end
    end

    assign mem_valid_o = valid_q;
    assign mem_we_o    = we_q;
    assign mem_user_o  = user_q;
    assign mem_addr_o  = addr_q;
    assign mem_be_o    = be_q;
    assign mem_wdata_o = wdata_q;
    assign wb_en_o     = wb_en_q;
    assign wb_value_o  = wb_q;
    assign err_o       = err_q;
endmodule

// File: rtl/user_ldst_agen_chk.sv
module user_ldst_agen_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid_i,
    input logic        req_store_i,
    input logic [1:0]  req_mode_i,
    input logic [2:0]  req_size_i,
    input logic [31:0] base_i,
    input logic [11:0] imm_i,
    input logic        mem_valid_o,
    input logic        mem_user_o,
    input logic [31:0] mem_addr_o,
    input logic [3:0]  mem_be_o,
    input logic        wb_en_o,
    input logic        err_o
);
    AST_USER_MARK: assert property (@(posedge clk) disable iff (rst)
        mem_valid_o |-> mem_user_o); // R1

    AST_OFFS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_mode_i == 2'd0) |=>
            (!mem_valid_o || mem_addr_o == $past(base_i) + {20'd0, $past(imm_i)})); // R2

    AST_OFFS_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_mode_i == 2'd0) |=> !wb_en_o); // R2

    AST_POST_ADDR: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_mode_i != 2'd0) |=>
            (!mem_valid_o || mem_addr_o == $past(base_i))); // R3

    AST_SIGNED_STORE: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_store_i && (req_size_i == 3'd1 || req_size_i == 3'd3))
            |=> (err_o && !mem_valid_o)); // R8

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(err_o && mem_valid_o)); // R11

    AST_WB_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> mem_valid_o); // R3

    AST_BE_COUNT: assert property (@(posedge clk) disable iff (rst)
        mem_valid_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2
                         || $countones(mem_be_o) == 4)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (!mem_valid_o && !err_o)); // R11
endmodule

bind user_ldst_agen user_ldst_agen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_store_i (req_store_i),
    .req_mode_i  (req_mode_i),
    .req_size_i  (req_size_i),
    .base_i      (base_i),
    .imm_i       (imm_i),
    .mem_valid_o (mem_valid_o),
    .mem_user_o  (mem_user_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .wb_en_o     (wb_en_o),
    .err_o       (err_o)
);

// File: tb/test_user_ldst_agen.sv
module test_user_ldst_agen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0, req_store_i = 1'b0, req_sub_i = 1'b0;
    logic [1:0]  req_mode_i = '0;
    logic [2:0]  req_size_i = '0;
    logic [31:0] base_i = '0, offreg_i = '0, st_data_i = '0, rdata_i = '0;
    logic [11:0] imm_i = '0;
    logic        offreg_is_pc_i = 1'b0, carry_i = 1'b0;
    logic [1:0]  shift_kind_i = '0;
    logic [4:0]  shift_amt_i = '0;
    logic        mem_valid_o, mem_we_o, mem_user_o, wb_en_o, err_o;
    logic [31:0] mem_addr_o, mem_wdata_o, wb_value_o, ld_result_o;
    logic [3:0]  mem_be_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    user_ldst_agen i_user_ldst_agen (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_store_i(req_store_i),
        .req_mode_i(req_mode_i), .req_sub_i(req_sub_i), .req_size_i(req_size_i),
        .base_i(base_i), .imm_i(imm_i), .offreg_i(offreg_i),
        .offreg_is_pc_i(offreg_is_pc_i), .shift_kind_i(shift_kind_i),
        .shift_amt_i(shift_amt_i), .carry_i(carry_i), .st_data_i(st_data_i),
        .rdata_i(rdata_i), .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o),
        .mem_user_o(mem_user_o), .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
        .mem_wdata_o(mem_wdata_o), .wb_en_o(wb_en_o), .wb_value_o(wb_value_o),
        .err_o(err_o), .ld_result_o(ld_result_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge; outputs are read at the next falling edge.
    task automatic issue(input logic st, input logic [1:0] md, input logic sb,
                         input logic [2:0] sz, input logic [31:0] bs, input logic [11:0] im,
                         input logic [31:0] orv, input logic pc, input logic [1:0] kd,
                         input logic [4:0] am, input logic cy, input logic [31:0] dt);
        req_store_i = st; req_mode_i = md; req_sub_i = sb; req_size_i = sz;
        base_i = bs; imm_i = im; offreg_i = orv; offreg_is_pc_i = pc;
        shift_kind_i = kd; shift_amt_i = am; carry_i = cy; st_data_i = dt;
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 reset valid", 32'(mem_valid_o), 32'd0);
        chk("R11 reset err", 32'(err_o), 32'd0);
        chk("R3 reset wb_en", 32'(wb_en_o), 32'd0);
    endtask

    task automatic t_offset_mode();
        issue(0, 2'd0, 0, 3'd4, 32'h1000, 12'h040, 0, 0, 0, 0, 0, 0);
        chk("R2 offs addr", mem_addr_o, 32'h1040);
        chk("R2 offs valid", 32'(mem_valid_o), 32'd1);
        chk("R2 offs no wb", 32'(wb_en_o), 32'd0);
        chk("R1 user mark", 32'(mem_user_o), 32'd1);
        issue(0, 2'd0, 0, 3'd4, 32'h1000, 12'd256, 0, 0, 0, 0, 0, 0);
        chk("R2 offs range err", 32'(err_o), 32'd1);
        chk("R2 offs range no issue", 32'(mem_valid_o), 32'd0);
    endtask

    task automatic t_post_imm();
        issue(0, 2'd1, 0, 3'd4, 32'h2000, 12'd4095, 0, 0, 0, 0, 0, 0);
        chk("R3 post addr", mem_addr_o, 32'h2000);
        chk("R3 post wb_en", 32'(wb_en_o), 32'd1);
        chk("R3 post wb add", wb_value_o, 32'h2FFF);
        issue(0, 2'd1, 1, 3'd4, 32'h2000, 12'd16, 0, 0, 0, 0, 0, 0);
        chk("R3 post wb sub", wb_value_o, 32'h1FF0);
    endtask

    task automatic t_ranges();
        issue(0, 2'd1, 0, 3'd2, 32'h100, 12'd256, 0, 0, 0, 0, 0, 0);
        chk("R4 half 256 err", 32'(err_o), 32'd1);
        chk("R4 half 256 no issue", 32'(mem_valid_o), 32'd0);
        issue(0, 2'd1, 0, 3'd0, 32'h100, 12'd4095, 0, 0, 0, 0, 0, 0);
        chk("R4 ubyte 4095 ok", 32'(err_o), 32'd0);
        chk("R4 ubyte 4095 wb", wb_value_o, 32'h10FF);
        issue(0, 2'd1, 0, 3'd1, 32'h100, 12'd255, 0, 0, 0, 0, 0, 0);
        chk("R4 sbyte 255 ok", 32'(mem_valid_o), 32'd1);
        issue(0, 2'd3, 0, 3'd4, 32'h100, 12'd0, 0, 0, 0, 0, 0, 0);
        chk("R4 mode3 err", 32'(err_o), 32'd1);
        issue(0, 2'd0, 0, 3'd6, 32'h100, 12'd0, 0, 0, 0, 0, 0, 0);
        chk("R4 size6 err", 32'(err_o), 32'd1);
    endtask

    task automatic t_shifts();
        issue(0, 2'd2, 0, 3'd4, 32'h100, 0, 32'h8000_0001, 0, 2'd0, 5'd4, 0, 0);
        chk("R5 lsl4", wb_value_o, 32'h110);
        chk("R3 reg post addr", mem_addr_o, 32'h100);
        issue(0, 2'd2, 1, 3'd4, 32'h100, 0, 32'h8000_0001, 0, 2'd0, 5'd4, 0, 0);
        chk("R5 lsl4 sub", wb_value_o, 32'hF0);
        issue(0, 2'd2, 0, 3'd4, 32'h100, 0, 32'h8000_0001, 0, 2'd1, 5'd0, 0, 0);
        chk("R5 lsr32", wb_value_o, 32'h100);
        issue(0, 2'd2, 0, 3'd4, 32'h100, 0, 32'h8000_0001, 0, 2'd2, 5'd0, 0, 0);
        chk("R5 asr32", wb_value_o, 32'hFF);
        issue(0, 2'd2, 0, 3'd4, 32'h100, 0, 32'h8000_0010, 0, 2'd2, 5'd4, 0, 0);
        chk("R5 asr4", wb_value_o, 32'hF800_0101);
        issue(0, 2'd2, 0, 3'd0, 32'h100, 0, 32'h3, 0, 2'd3, 5'd1, 0, 0);
        chk("R5 ror1", wb_value_o, 32'h8000_0101);
        issue(0, 2'd2, 0, 3'd4, 32'h100, 0, 32'h2, 0, 2'd3, 5'd0, 1, 0);
        chk("R5 rrx c1", wb_value_o, 32'h8000_0101);
        issue(0, 2'd2, 0, 3'd4, 32'h100, 0, 32'h2, 0, 2'd3, 5'd0, 0, 0);
        chk("R5 rrx c0", wb_value_o, 32'h101);
    endtask

    task automatic t_unshifted();
        issue(0, 2'd2, 0, 3'd2, 32'h100, 0, 32'h10, 0, 2'd0, 5'd4, 0, 0);
        chk("R6 half unshifted", wb_value_o, 32'h110);
        issue(0, 2'd2, 0, 3'd1, 32'h100, 0, 32'h10, 0, 2'd1, 5'd0, 0, 0);
        chk("R6 sbyte unshifted", wb_value_o, 32'h110);
    endtask

    task automatic t_load_ext();
        issue(0, 2'd0, 0, 3'd0, 32'h0, 0, 0, 0, 0, 0, 0, 0);
        rdata_i = 32'h80F0_7F85; #1;
        chk("R7 ub lane0", ld_result_o, 32'h85);
        chk("R10 load wdata zero", mem_wdata_o, 32'h0);
        chk("R10 load we", 32'(mem_we_o), 32'd0);
        issue(0, 2'd0, 0, 3'd1, 32'h0, 0, 0, 0, 0, 0, 0, 0); #1;
        chk("R7 sb lane0", ld_result_o, 32'hFFFF_FF85);
        issue(0, 2'd0, 0, 3'd1, 32'h1, 0, 0, 0, 0, 0, 0, 0); #1;
        chk("R7 sb lane1", ld_result_o, 32'h7F);
        issue(0, 2'd0, 0, 3'd2, 32'h2, 0, 0, 0, 0, 0, 0, 0); #1;
        chk("R7 uh lane2", ld_result_o, 32'h80F0);
        issue(0, 2'd0, 0, 3'd3, 32'h2, 0, 0, 0, 0, 0, 0, 0); #1;
        chk("R7 sh lane2", ld_result_o, 32'hFFFF_80F0);
        issue(0, 2'd0, 0, 3'd4, 32'h0, 0, 0, 0, 0, 0, 0, 0); #1;
        chk("R7 word", ld_result_o, 32'h80F0_7F85);
    endtask

    task automatic t_signed_store();
        issue(1, 2'd0, 0, 3'd1, 32'h40, 0, 0, 0, 0, 0, 0, 32'h1);
        chk("R8 sb store err", 32'(err_o), 32'd1);
        chk("R8 sb store no issue", 32'(mem_valid_o), 32'd0);
        issue(1, 2'd1, 0, 3'd3, 32'h40, 12'd2, 0, 0, 0, 0, 0, 32'h1);
        chk("R8 sh store err", 32'(err_o), 32'd1);
        chk("R8 sh store no wb", 32'(wb_en_o), 32'd0);
    endtask

    task automatic t_pc_offset();
        issue(0, 2'd2, 0, 3'd4, 32'h40, 0, 32'h4, 1, 0, 0, 0, 0);
        chk("R9 pc offset err", 32'(err_o), 32'd1);
        chk("R9 pc offset no issue", 32'(mem_valid_o), 32'd0);
    endtask

    task automatic t_lanes();
        issue(1, 2'd0, 0, 3'd0, 32'h3, 0, 0, 0, 0, 0, 0, 32'h1234_5678);
        chk("R10 byte be", 32'(mem_be_o), 32'h8);
        chk("R10 byte wdata", mem_wdata_o, 32'h7878_7878);
        chk("R10 store we", 32'(mem_we_o), 32'd1);
        chk("R1 store user", 32'(mem_user_o), 32'd1);
        issue(1, 2'd0, 0, 3'd2, 32'h2, 0, 0, 0, 0, 0, 0, 32'h1234_5678);
        chk("R10 half be", 32'(mem_be_o), 32'hC);
        chk("R10 half wdata", mem_wdata_o, 32'h5678_5678);
        issue(1, 2'd0, 0, 3'd4, 32'h0, 0, 0, 0, 0, 0, 0, 32'h1234_5678);
        chk("R10 word be", 32'(mem_be_o), 32'hF);
        chk("R10 word wdata", mem_wdata_o, 32'h1234_5678);
        @(negedge clk);
        chk("R11 idle after req", 32'(mem_valid_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_offset_mode();
        t_post_imm();
        t_ranges();
        t_shifts();
        t_unshifted();
        t_load_ext();
        t_signed_store();
        t_pc_offset();
        t_lanes();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule